// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block is the single configuration store of a dataflow accelerator. Every functional unit takes its settings from here and holds none of its own. A processor writes 32-bit configuration words through a simple memory-mapped request port that supports per-byte write enables. It may write at any time, including while the accelerator is running.

The block keeps two copies of the configuration. The working copy is the one the processor writes and reads back. The snapshot copy drives the unit configuration outputs. The snapshot is loaded from the working copy in one cycle, at the moment a run start is accepted. It then stays frozen until the next accepted start. This lets firmware build the next run's configuration while the current run proceeds.

A small run controller tracks the run. It has two states, IDLE and RUN, and two transitions:
- GO moves IDLE to RUN on a start pulse.
- FINISH moves RUN to IDLE when every unit signals completion in the same cycle.

Several unit outputs may be fed from one stored word, so units can share a configuration field.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After reset:
  - every working word and every unit configuration output is zero;
  - req_ready is low;
  - the status word reads zero.
- R2: A request is accepted on a rising edge where req_valid is high and req_ready is low. req_ready is high during the single cycle that follows, and rsp_rdata is valid in that cycle for a read. A requester holds req_valid until it sees req_ready.
- R3: A request with req_wstrb non-zero is a write. Bit k of req_wstrb enables byte k (bits 8k+7..8k) of the addressed word, and unselected bytes keep their value. A request with req_wstrb zero is a read and modifies nothing.
- R4: Reading addresses 0 to NUM_WORDS-1 returns the working word, not the snapshot.
- R5: On an accepted start (GO), all working words are copied into the snapshot in that one cycle. A write accepted in that same cycle is not part of the snapshot.
- R6: Unit configuration outputs are driven only by the snapshot. Writes made while busy do not change them.
- R7: A run_start pulse while in RUN is ignored: the snapshot, the outputs and the state are unchanged.
- R8: In RUN, FINISH happens when all unit_done bits are high in the same cycle: busy clears and done sets. A partial set of done bits keeps the block in RUN. done clears on the next GO.
- R9: Address NUM_WORDS is a read-only status word, bit 0 busy and bit 1 done, other bits zero. Writes to it, and to any address above NUM_WORDS, are ignored. Reads above NUM_WORDS return zero.
- R10: Unit u is driven by snapshot word u mod NUM_WORDS, so units whose indices differ by NUM_WORDS carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte write enables; zero means read |
| req_ready | output | 1 | Access completed (one cycle after acceptance) |
| rsp_rdata | output | 32 | Read data, valid while req_ready is high after a read |
| run_start | input | 1 | Run start pulse |
| unit_done | input | NUM_UNITS | Per-unit completion flags |
| unit_cfg | output | NUM_UNITS*32 | Snapshot configuration per unit, unit 0 in the low bits |

## Verification
The bench builds the block with NUM_WORDS=4 and NUM_UNITS=6, which gives a 3-bit address.

Units 4 and 5 therefore share words 0 and 1, so the sharing rule can be observed. Address 4 is the status word, and addresses 5 to 7 fall outside the map, so ignored writes and zero reads are both reachable. Six done bits make partial completion patterns common under random stimulus.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
    localparam int WORD_W = 32;
    localparam int STRB_W = WORD_W / 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [WORD_W-3:0] rsvd;
        logic              done;
        logic              busy;
    } status_t;
endpackage

// File: rtl/cfg_work_regs.sv
module cfg_work_regs
    import cfg_shadow_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [STRB_W-1:0]           wr_strb,
    output logic [NUM_WORDS*WORD_W-1:0] work_flat
);
    logic [NUM_WORDS*WORD_W-1:0] work_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (wr_addr == ADDR_W'(w)) begin
                    for (int b = 0; b < STRB_W; b++) begin
                        if (wr_strb[b]) begin
                            work_q[w*WORD_W + b*8 +: 8] <= wr_data[b*8 +: 8];
                        end
                    end
                end
            end
        end
    end

    assign work_flat = work_q;
endmodule

// File: rtl/cfg_snapshot_regs.sv
module cfg_snapshot_regs
    import cfg_shadow_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int NUM_UNITS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        capture,
    input  logic [NUM_WORDS*WORD_W-1:0] work_flat,
    output logic [NUM_UNITS*WORD_W-1:0] unit_cfg
);
    logic [NUM_WORDS*WORD_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (capture) begin
            snap_q <= work_flat;
        end
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_fanout
        localparam int SRC = u % NUM_WORDS;
        assign unit_cfg[u*WORD_W +: WORD_W] = snap_q[SRC*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/cfg_run_ctrl.sv
module cfg_run_ctrl
    import cfg_shadow_pkg::*;
#(
    parameter int NUM_UNITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_start,
    input  logic [NUM_UNITS-1:0] unit_done,
    output logic                 start_accept,
    output logic                 busy,
    output logic                 done
);
    run_state_e state_q, state_d;
    logic       go, finish;
    logic       done_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: GO (IDLE->RUN), FINISH (RUN->IDLE).
    always_comb begin
        state_d = state_q;
        go      = 1'b0;
        finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_start) begin
                    state_d = ST_RUN;
                    go      = 1'b1;
                end
            end
            ST_RUN: begin
                if (&unit_done) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Done flag: set on FINISH, cleared on GO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (go) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        start_accept = go;
        busy         = (state_q == ST_RUN);
        done         = done_q;
    end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import cfg_shadow_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int NUM_UNITS = 6,
    parameter int ADDR_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [WORD_W-1:0]           req_wdata,
    input  logic [STRB_W-1:0]           req_wstrb,
    output logic                        req_ready,
    output logic [WORD_W-1:0]           rsp_rdata,
    input  logic                        run_start,
    input  logic [NUM_UNITS-1:0]        unit_done,
    output logic [NUM_UNITS*WORD_W-1:0] unit_cfg
);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_WORDS);

    logic                        ready_q;
    logic [WORD_W-1:0]           rdata_q;
    logic                        accept, is_write, wr_en;
    logic                        start_accept, run_busy, run_done;
    logic [NUM_WORDS*WORD_W-1:0] work_flat;
    logic [WORD_W-1:0]           rd_word;
    status_t                     status;

    assign accept   = req_valid && !ready_q;
    assign is_write = |req_wstrb;
    assign wr_en    = accept && is_write && (req_addr < STATUS_ADDR);

    cfg_work_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_work (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (req_addr),
        .wr_data   (req_wdata),
        .wr_strb   (req_wstrb),
        .work_flat (work_flat)
    );

    cfg_snapshot_regs #(.NUM_WORDS(NUM_WORDS), .NUM_UNITS(NUM_UNITS)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (start_accept),
        .work_flat (work_flat),
        .unit_cfg  (unit_cfg)
    );

    cfg_run_ctrl #(.NUM_UNITS(NUM_UNITS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_start    (run_start),
        .unit_done    (unit_done),
        .start_accept (start_accept),
        .busy         (run_busy),
        .done         (run_done)
    );

    always_comb begin
        status      = '0;
        status.busy = run_busy;
        status.done = run_done;
    end

    always_comb begin
        rd_word = '0;
        if (req_addr < STATUS_ADDR) begin
            rd_word = work_flat[int'(req_addr)*WORD_W +: WORD_W];
        end else if (req_addr == STATUS_ADDR) begin
            rd_word = status;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= accept;
            if (accept && !is_write) begin
                rdata_q <= rd_word;
            end
        end
    end

    assign req_ready = ready_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/cfg_shadow_bank_chk.sv
module cfg_shadow_bank_chk #(
    parameter int NUM_UNITS = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   run_start,
    input logic [NUM_UNITS-1:0]   unit_done,
    input logic                   busy,
    input logic                   done,
    input logic [NUM_UNITS*32-1:0] unit_cfg
);
    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_ready); // R2

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R2

    AST_GO_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && run_start |=> busy && !done); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(unit_cfg)); // R6

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && run_start && !(&unit_done) |=> busy && $stable(unit_cfg)); // R7

    AST_PARTIAL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(&unit_done) |=> busy); // R8

    AST_NOT_BUSY_AND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8
endmodule

bind cfg_shadow_bank cfg_shadow_bank_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .run_start (run_start),
    .unit_done (unit_done),
    .busy      (run_busy),
    .done      (run_done),
    .unit_cfg  (unit_cfg)
);

// File: tb/cfg_shadow_bank_bench.sv
module cfg_shadow_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int NU = 6;
    localparam int AW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [31:0]    req_wdata = '0;
    logic [3:0]     req_wstrb = '0;
    logic           req_ready;
    logic [31:0]    rsp_rdata;
    logic           run_start = 1'b0;
    logic [NU-1:0]  unit_done = '0;
    logic [NU*32-1:0] unit_cfg;

    int errors = 0;
    int checks = 0;

    logic [31:0] m_work [NW];
    logic [31:0] m_snap [NW];
    logic        m_ready, m_busy, m_done, m_rd_chk;
    logic [31:0] m_rd;
    string       m_rd_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_shadow_bank #(.NUM_WORDS(NW), .NUM_UNITS(NU)) u_cfg_shadow_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wstrb (req_wstrb),
        .req_ready (req_ready),
        .rsp_rdata (rsp_rdata),
        .run_start (run_start),
        .unit_done (unit_done),
        .unit_cfg  (unit_cfg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        if (int'(a) < NW) return m_work[a];
        if (int'(a) == NW) return {30'd0, m_done, m_busy};
        return 32'd0;
    endfunction

    // One clock cycle: drive at a falling edge, model at the rising edge, check at the next falling edge.
    task automatic cyc(input logic v, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [3:0] s, input logic st, input logic [NU-1:0] ud);
        logic acc, go;
        req_valid = v; req_addr = a; req_wdata = d; req_wstrb = s;
        run_start = st; unit_done = ud;
        @(posedge clk);
        acc = v && !m_ready;
        go  = st && !m_busy;
        m_rd_chk = 1'b0;
        if (acc && s == 4'd0) begin
            m_rd = model_read(a);
            m_rd_chk = 1'b1;
            m_rd_tag = (int'(a) < NW) ? "R4 read working word" : "R9 status/unmapped read";
        end
        if (go) for (int w = 0; w < NW; w++) m_snap[w] = m_work[w];
        if (acc && s != 4'd0 && int'(a) < NW) m_work[a] = merge(m_work[a], d, s);
        m_ready = acc;
        if (go) begin
            m_busy = 1'b1; m_done = 1'b0;
        end else if (m_busy && &ud) begin
            m_busy = 1'b0; m_done = 1'b1;
        end
        @(negedge clk);
        chk("R2 req_ready", {31'd0, req_ready}, {31'd0, m_ready});
        if (m_rd_chk) chk(m_rd_tag, rsp_rdata, m_rd);
        for (int u = 0; u < NU; u++)
            chk("R6 unit_cfg from snapshot", unit_cfg[u*32 +: 32], m_snap[u % NW]);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
        cyc(1'b1, a, d, s, 1'b0, '0);
        cyc(1'b0, '0, '0, '0, 1'b0, '0);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] q);
        cyc(1'b1, a, '0, 4'd0, 1'b0, '0);
        q = rsp_rdata;
        cyc(1'b0, '0, '0, '0, 1'b0, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog act=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] q;
        void'($urandom(32'd20240611));
        for (int w = 0; w < NW; w++) begin m_work[w] = '0; m_snap[w] = '0; end
        m_ready = 0; m_busy = 0; m_done = 0; m_rd_chk = 0; m_rd = '0; m_rd_tag = "";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 req_ready after reset", {31'd0, req_ready}, 32'd0);
        for (int u = 0; u < NU; u++) chk("R1 unit_cfg after reset", unit_cfg[u*32 +: 32], 32'd0);
        rd(3'd4, q); chk("R1 status after reset", q, 32'd0);
        rd(3'd2, q); chk("R1 working word after reset", q, 32'd0);

        // R3: byte strobes; zero strobe is a read
        wr(3'd1, 32'hAABBCCDD, 4'hF);
        wr(3'd1, 32'h11223344, 4'b0101);
        rd(3'd1, q); chk("R3 byte strobe merge", q, 32'hAA22CC44);
        cyc(1'b1, 3'd2, 32'hDEADBEEF, 4'd0, 1'b0, '0);
        cyc(1'b0, '0, '0, '0, 1'b0, '0);
        rd(3'd2, q); chk("R3 zero strobe writes nothing", q, 32'd0);

        // R5: write in the same cycle as GO is not captured
        wr(3'd0, 32'h12345678, 4'hF);
        cyc(1'b1, 3'd0, 32'hFFFFFFFF, 4'hF, 1'b1, '0);
        cyc(1'b0, '0, '0, '0, 1'b0, '0);
        chk("R5 snapshot excludes same-cycle write", unit_cfg[0 +: 32], 32'h12345678);
        chk("R10 unit4 shares word0", unit_cfg[4*32 +: 32], 32'h12345678);
        chk("R10 unit5 shares word1", unit_cfg[5*32 +: 32], 32'hAA22CC44);
        rd(3'd0, q); chk("R4 read returns working word", q, 32'hFFFFFFFF);
        rd(3'd4, q); chk("R9 status busy", q, 32'd1);

        // R6: writes while busy leave outputs alone
        wr(3'd1, 32'h0, 4'hF);
        chk("R6 unit1 frozen during run", unit_cfg[32 +: 32], 32'hAA22CC44);

        // R7: start while busy is ignored
        cyc(1'b0, '0, '0, '0, 1'b1, '0);
        chk("R7 restart ignored unit1", unit_cfg[32 +: 32], 32'hAA22CC44);
        rd(3'd4, q); chk("R7 still busy", q, 32'd1);

        // R8: partial done keeps RUN; all done finishes
        cyc(1'b0, '0, '0, '0, 1'b0, 6'b011111);
        rd(3'd4, q); chk("R8 partial done stays busy", q, 32'd1);
        cyc(1'b0, '0, '0, '0, 1'b0, 6'b111111);
        rd(3'd4, q); chk("R8 finish sets done", q, 32'd2);
        cyc(1'b0, '0, '0, '0, 1'b1, '0);
        chk("R5 new snapshot unit1", unit_cfg[32 +: 32], 32'd0);
        chk("R10 unit5 follows word1", unit_cfg[5*32 +: 32], 32'd0);
        rd(3'd4, q); chk("R8 GO clears done", q, 32'd1);

        // R9: status and unmapped addresses ignore writes
        wr(3'd4, 32'hFFFFFFFF, 4'hF);
        rd(3'd4, q); chk("R9 status write ignored", q, 32'd1);
        wr(3'd6, 32'h5A5A5A5A, 4'hF);
        rd(3'd6, q); chk("R9 unmapped read zero", q, 32'd0);
        for (int w = 0; w < NW; w++) begin
            rd(AW'(w), q); chk("R9 unmapped write touched no word", q, m_work[w]);
        end
        cyc(1'b0, '0, '0, '0, 1'b0, '1);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0] s;
            logic [NU-1:0] ud;
            s  = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom % 16);
            ud = ($urandom % 4 == 0) ? '1 : NU'($urandom % 64);
            cyc(1'($urandom % 2), AW'($urandom % 8), $urandom, s, ($urandom % 8 == 0), ud);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule